// File: doc/BRIEF.md
# Inverter Zone Reference Search

This block picks the zone reference that a multilevel inverter's gate sequencer uses to set the boundary between its inner and outer modulation zones. A higher reference gives a lower output amplitude, and a lower reference gives a higher one. The block is run once per control update. A start pulse captures the measured DC-link voltage and the wanted output peak. The block then predicts the output peak for one candidate reference per clock cycle and moves the candidate one step at a time, in the direction the sign of the error calls for. It keeps the candidate with the smallest absolute error.

The reference is held as a small integer code. Code `c` stands for 0.30 + 0.05·c, so the nine legal codes cover 0.30 to 0.70 in steps of 0.05, and code 4 is the nominal 0.50. The prediction is the captured input voltage times a per-code gain. The gain table falls as the code rises, which models the inverse effect of the reference on the output. Each search starts from the code currently applied. The previous code stays on the output until the search ends. A one-cycle done pulse comes with the new code.

Top module: `zone_ref_search`

## Requirements
- R1: `sel_code_o` carries a code from 0 to 8, where code c means a zone reference of 0.30 + 0.05·c. After reset it is 4 (0.50).
- R2: The predicted peak for code c is floor(vin · (448 − 24·c) / 256). The gain is 448/256 at code 0 and 256/256 at code 8, and it falls by 24/256 per code. The error is vref minus the predicted peak.
- R3: When start is sampled, vin_i and vref_i are captured. The search uses only those captured values, and changes on the inputs during a search have no effect on its result.
- R4: A positive error at the starting code moves the search toward lower codes, which give a higher output. A negative error moves it toward higher codes. The candidate code moves by at most one per clock cycle.
- R5: The selected code minimises |vref − predicted peak| over the codes 0 to 8.
- R6: When two codes give the same minimum absolute error, the one closer to code 4 is selected.
- R7: The code never leaves the range 0 to 8. When the error still points past the end of the range, the result is that end code.
- R8: done_o is high for exactly one cycle per search. `sel_code_o` changes only in a cycle where done_o is high, and it is held at all other times.
- R9: done_o rises at most 9 clocks after the clock edge that samples start. It rises exactly 1 clock after that edge when the error at the starting code is zero. A start pulse given while a search is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launches one search when the block is idle |
| vin_i | input | VIN_W (12) | Measured DC-link voltage, unsigned integer |
| vref_i | input | VREF_W (13) | Wanted output peak, unsigned integer |
| sel_code_o | output | clog2(NUM_CODES) (4) | Applied zone reference code |
| done_o | output | 1 | One-cycle pulse that comes with an updated code |

## Verification
Targets that fall exactly on the nominal prediction show the early exit, with no move away from code 4. Targets far above or below every prediction push the search into code 0 or code 8. These tell saturation apart from a real minimum. With the input at 256 every gain maps to an exact integer, so targets placed halfway between two neighbouring predictions test the tie rule on both sides of the nominal code. Targets at mixed input voltages, checked against an exhaustive minimum over all nine codes and reached from both ends of the range, show whether the step direction and the stop-on-worsening rule find the global minimum. A run disturbed by new inputs and a second start shows whether the captured values are the only ones used.

// File: rtl/zrs_pkg.sv
package zrs_pkg;
   typedef enum logic [0:0] {
      ZRS_IDLE = 1'b0,
      ZRS_RUN  = 1'b1
   } zrs_state_e;
endpackage

// File: rtl/zrs_gain_rom.sv
module zrs_gain_rom #(
   parameter int NUM_CODES = 9,
   parameter int GAIN_W    = 10,
   parameter int GAIN_TOP  = 448,
   parameter int GAIN_DEC  = 24
) (
   input  logic [$clog2(NUM_CODES)-1:0] code_i,
   output logic [GAIN_W-1:0]            gain_o
);
   localparam int CODE_W = $clog2(NUM_CODES);

   logic [GAIN_W-1:0] tbl [NUM_CODES];

   // Falling gain table computed per entry.
   for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
      assign tbl[g] = GAIN_W'(GAIN_TOP - g * GAIN_DEC);
   end

   generate
      if ((1 << CODE_W) == NUM_CODES) begin : g_full
         assign gain_o = tbl[code_i];
      end else begin : g_guard
         assign gain_o = (int'(code_i) < NUM_CODES) ? tbl[code_i] : tbl[NUM_CODES-1];
      end
   endgenerate
endmodule

// File: rtl/zrs_predict.sv
module zrs_predict #(
   parameter int VIN_W     = 12,
   parameter int VREF_W    = 13,
   parameter int GAIN_W    = 10,
   parameter int GAIN_FRAC = 8,
   parameter int MAGW      = 14
) (
   input  logic [VIN_W-1:0]  vin_i,
   input  logic [VREF_W-1:0] vref_i,
   input  logic [GAIN_W-1:0] gain_i,
   output logic [MAGW-1:0]   abs_err_o,
   output logic              err_neg_o,
   output logic              err_zero_o
);
   localparam int PROD_W = VIN_W + GAIN_W;
   localparam int PRED_W = PROD_W - GAIN_FRAC;
   localparam int ERR_W  = MAGW + 1;

   logic [PROD_W-1:0]       prod;
   logic [PRED_W-1:0]       pred;
   logic signed [ERR_W-1:0] err;
   logic signed [ERR_W-1:0] err_mag;

   assign prod = PROD_W'(vin_i) * PROD_W'(gain_i);
   assign pred = prod[PROD_W-1:GAIN_FRAC];
   assign err  = $signed({1'b0, MAGW'(vref_i)}) - $signed({1'b0, MAGW'(pred)});
   assign err_mag    = err[ERR_W-1] ? -err : err;
   assign abs_err_o  = err_mag[MAGW-1:0];
   assign err_neg_o  = err[ERR_W-1];
   assign err_zero_o = (err == '0);
endmodule

// File: rtl/zrs_step_ctrl.sv
module zrs_step_ctrl
   import zrs_pkg::*;
#(
   parameter int NUM_CODES = 9,
   parameter int NOM_CODE  = 4,
   parameter int MAX_ITER  = 9,
   parameter int MAGW      = 14
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic                          start_i,
   input  logic [MAGW-1:0]               abs_err_i,
   input  logic                          err_neg_i,
   input  logic                          err_zero_i,
   output logic                          load_o,
   output logic                          busy_o,
   output logic [$clog2(NUM_CODES)-1:0]  cand_o,
   output logic [$clog2(NUM_CODES)-1:0]  sel_o,
   output logic [$clog2(MAX_ITER+1)-1:0] iter_o,
   output logic                          done_o
);
   localparam int CODE_W = $clog2(NUM_CODES);
   localparam int ITER_W = $clog2(MAX_ITER+1);
   localparam logic [CODE_W-1:0] MAXC = CODE_W'(NUM_CODES-1);
   localparam logic [CODE_W-1:0] NOMC = CODE_W'(NOM_CODE);

   zrs_state_e        state_q;
   logic [CODE_W-1:0] cand_q, best_q, sel_q, pick, nxt;
   logic [MAGW-1:0]   best_abs_q;
   logic [ITER_W-1:0] iter_q;
   logic              dir_up_q, done_q;
   logic              first, improve, tie, dir_up, at_bound, at_cap, finish;

   function automatic int nom_dist(logic [CODE_W-1:0] c);
      int d;
      d = int'(c) - NOM_CODE;
      return (d < 0) ? -d : d;
   endfunction

   always_comb begin
      first    = (iter_q == '0);
      improve  = first || (abs_err_i < best_abs_q);
      tie      = !first && (abs_err_i == best_abs_q);
      dir_up   = first ? err_neg_i : dir_up_q;
      at_bound = dir_up ? (cand_q == MAXC) : (cand_q == '0);
      at_cap   = (iter_q == ITER_W'(MAX_ITER-1));
      finish   = !improve || err_zero_i || at_bound || at_cap;
      nxt      = dir_up ? cand_q + CODE_W'(1) : cand_q - CODE_W'(1);
      if (improve)
         pick = cand_q;
      else if (tie && (nom_dist(cand_q) < nom_dist(best_q)))
         pick = cand_q;
      else
         pick = best_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q    <= ZRS_IDLE;
         cand_q     <= NOMC;
         best_q     <= NOMC;
         sel_q      <= NOMC;
         best_abs_q <= '0;
         iter_q     <= '0;
         dir_up_q   <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ZRS_IDLE: begin
               if (start_i) begin
                  cand_q  <= sel_q;
                  iter_q  <= '0;
                  state_q <= ZRS_RUN;
               end
            end
            default: begin
               if (first) dir_up_q <= err_neg_i;
               if (improve) begin
                  best_q     <= cand_q;
                  best_abs_q <= abs_err_i;
               end
               if (finish) begin
                  sel_q   <= pick;
                  done_q  <= 1'b1;
                  state_q <= ZRS_IDLE;
               end else begin
                  cand_q <= nxt;
                  iter_q <= iter_q + ITER_W'(1);
               end
            end
         endcase
      end
   end

   assign load_o = (state_q == ZRS_IDLE) && start_i;
   assign busy_o = (state_q == ZRS_RUN);
   assign cand_o = cand_q;
   assign sel_o  = sel_q;
   assign iter_o = iter_q;
   assign done_o = done_q;
endmodule

// File: rtl/zone_ref_search.sv
module zone_ref_search #(
   parameter int NUM_CODES = 9,
   parameter int NOM_CODE  = (NUM_CODES - 1) / 2,
   parameter int MAX_ITER  = NUM_CODES,
   parameter int VIN_W     = 12,
   parameter int VREF_W    = 13,
   parameter int GAIN_W    = 10,
   parameter int GAIN_FRAC = 8,
   parameter int GAIN_TOP  = 448,
   parameter int GAIN_DEC  = 24
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic                         start_i,
   input  logic [VIN_W-1:0]             vin_i,
   input  logic [VREF_W-1:0]            vref_i,
   output logic [$clog2(NUM_CODES)-1:0] sel_code_o,
   output logic                         done_o
);
   localparam int CODE_W = $clog2(NUM_CODES);
   localparam int ITER_W = $clog2(MAX_ITER+1);
   localparam int PRED_W = VIN_W + GAIN_W - GAIN_FRAC;
   localparam int MAGW   = (PRED_W > VREF_W) ? PRED_W : VREF_W;

   // Elaboration-time parameter checks.
   generate
      if (NUM_CODES < 3) begin : g_bad_codes
         $error("zone_ref_search: NUM_CODES must be at least 3");
      end
      if (NOM_CODE < 0 || NOM_CODE >= NUM_CODES) begin : g_bad_nom
         $error("zone_ref_search: NOM_CODE out of range");
      end
      if (MAX_ITER < 1) begin : g_bad_iter
         $error("zone_ref_search: MAX_ITER must be positive");
      end
      if (GAIN_TOP - (NUM_CODES - 1) * GAIN_DEC <= 0 || GAIN_DEC <= 0) begin : g_bad_gain
         $error("zone_ref_search: gain table must stay positive and fall");
      end
      if (GAIN_TOP >= (1 << GAIN_W)) begin : g_bad_gw
         $error("zone_ref_search: GAIN_W too narrow for GAIN_TOP");
      end
   endgenerate

   logic [VIN_W-1:0]  vin_q;
   logic [VREF_W-1:0] vref_q;
   logic [GAIN_W-1:0] gain_w;
   logic [MAGW-1:0]   abs_err_w;
   logic              err_neg_w, err_zero_w, load_w, busy_w;
   logic [CODE_W-1:0] cand_w;
   logic [ITER_W-1:0] iter_w;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         vin_q  <= '0;
         vref_q <= '0;
      end else if (load_w) begin
         vin_q  <= vin_i;
         vref_q <= vref_i;
      end
   end

   zrs_gain_rom #(
      .NUM_CODES(NUM_CODES), .GAIN_W(GAIN_W),
      .GAIN_TOP(GAIN_TOP), .GAIN_DEC(GAIN_DEC)
   ) u_rom (
      .code_i(cand_w),
      .gain_o(gain_w)
   );

   zrs_predict #(
      .VIN_W(VIN_W), .VREF_W(VREF_W), .GAIN_W(GAIN_W),
      .GAIN_FRAC(GAIN_FRAC), .MAGW(MAGW)
   ) u_pred (
      .vin_i(vin_q),
      .vref_i(vref_q),
      .gain_i(gain_w),
      .abs_err_o(abs_err_w),
      .err_neg_o(err_neg_w),
      .err_zero_o(err_zero_w)
   );

   zrs_step_ctrl #(
      .NUM_CODES(NUM_CODES), .NOM_CODE(NOM_CODE),
      .MAX_ITER(MAX_ITER), .MAGW(MAGW)
   ) u_ctrl (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .start_i(start_i),
      .abs_err_i(abs_err_w),
      .err_neg_i(err_neg_w),
      .err_zero_i(err_zero_w),
      .load_o(load_w),
      .busy_o(busy_w),
      .cand_o(cand_w),
      .sel_o(sel_code_o),
      .iter_o(iter_w),
      .done_o(done_o)
   );
endmodule

// File: rtl/zrs_checker.sv
module zrs_checker #(
   parameter int NUM_CODES = 9,
   parameter int NOM_CODE  = 4,
   parameter int MAX_ITER  = 9
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          done,
   input logic                          busy,
   input logic [$clog2(NUM_CODES)-1:0]  sel,
   input logic [$clog2(NUM_CODES)-1:0]  cand,
   input logic [$clog2(MAX_ITER+1)-1:0] iter
);
   // R1: reset leaves the nominal code applied
   p_reset_nominal_r1: assert property (@(posedge clk)
      rst |=> (int'(sel) == NOM_CODE));

   // R7: applied and candidate codes stay in range
   p_code_range_r7: assert property (@(posedge clk) disable iff (rst)
      (int'(sel) < NUM_CODES) && (int'(cand) < NUM_CODES));

   // R8: applied code moves only together with done
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !$stable(sel) |-> done);

   // R8: done is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R4: the candidate moves by at most one code per cycle while searching
   p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |->
         ((int'(cand) == int'($past(cand))) ||
          (int'(cand) == int'($past(cand)) + 1) ||
          (int'(cand) + 1 == int'($past(cand)))));

   // R9: evaluation count stays under the cap
   p_iter_cap_r9: assert property (@(posedge clk) disable iff (rst)
      int'(iter) < MAX_ITER);
endmodule

bind zone_ref_search zrs_checker #(
   .NUM_CODES(NUM_CODES), .NOM_CODE(NOM_CODE), .MAX_ITER(MAX_ITER)
) u_zrs_checker (
   .clk(clk_i),
   .rst(rst_i),
   .done(done_o),
   .busy(busy_w),
   .sel(sel_code_o),
   .cand(cand_w),
   .iter(iter_w)
);

// File: tb/test_zone_ref_search.sv
module test_zone_ref_search;
   localparam int NCODES = 9;
   localparam int NOM    = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [11:0] vin = '0;
   logic [12:0] vref = '0;
   logic [3:0]  sel;
   logic        done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   zone_ref_search i_zone_ref_search (
      .clk_i(clk), .rst_i(rst), .start_i(start),
      .vin_i(vin), .vref_i(vref),
      .sel_code_o(sel), .done_o(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Requirement R2 gain formula
   function automatic int model_pred(int v, int c);
      return (v * (448 - 24 * c)) / 256;
   endfunction

   // R5/R6 exhaustive minimum with tie toward nominal
   function automatic int model_best(int v, int r);
      int best, best_e, e, d, bd;
      best = 0; best_e = -1;
      for (int c = 0; c < NCODES; c++) begin
         e = r - model_pred(v, c);
         if (e < 0) e = -e;
         d = (c > NOM) ? c - NOM : NOM - c;
         bd = (best > NOM) ? best - NOM : NOM - best;
         if (best_e < 0 || e < best_e || (e == best_e && d < bd)) begin
            best = c; best_e = e;
         end
      end
      return best;
   endfunction

   task automatic run_search(input int v, input int r, output int cyc);
      @(negedge clk);
      vin = 12'(v); vref = 13'(r); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!done && cyc < 40);
   endtask

   task automatic search_and_check(input int v, input int r, input string req);
      int cyc, exp;
      exp = model_best(v, r);
      run_search(v, r, cyc);
      check(done == 1'b1, {req, " done seen"}, int'(done), 1);
      check(int'(sel) == exp, {req, " selected code"}, int'(sel), exp);
      check(cyc <= 9, "R9 latency", cyc, 9);
      @(negedge clk);
      check(done == 1'b0, "R8 done single cycle", int'(done), 0);
   endtask

   task automatic t_reset;
      check(int'(sel) == NOM, "R1 reset code", int'(sel), NOM);
      check(done == 1'b0, "R8 done low after reset", int'(done), 0);
   endtask

   task automatic t_exact_nominal;
      int cyc;
      // 200*352/256 = 275 exactly at code 4
      run_search(200, 275, cyc);
      check(int'(sel) == 4, "R5 exact nominal", int'(sel), 4);
      check(cyc == 1, "R9 zero error exits in one clock", cyc, 1);
      @(negedge clk);
   endtask

   task automatic t_bounds;
      search_and_check(256, 500, "R7 lower bound");
      check(int'(sel) == 0, "R7 saturate at code 0", int'(sel), 0);
      search_and_check(256, 100, "R7 upper bound");
      check(int'(sel) == 8, "R7 saturate at code 8", int'(sel), 8);
   endtask

   task automatic t_ties;
      // from code 8: vref 340 ties codes 4 and 5 (352/328)
      search_and_check(256, 340, "R6 tie 4/5");
      check(int'(sel) == 4, "R6 tie keeps 4", int'(sel), 4);
      search_and_check(256, 500, "R4 move to 0");
      // from code 0: vref 292 ties codes 6 and 7 (304/280)
      search_and_check(256, 292, "R6 tie 6/7");
      check(int'(sel) == 6, "R6 tie keeps 6", int'(sel), 6);
      // ties codes 1 and 2 (424/400)
      search_and_check(256, 412, "R6 tie 1/2");
      check(int'(sel) == 2, "R6 tie keeps 2", int'(sel), 2);
   endtask

   task automatic t_direction;
      int v [5] = '{150, 300, 1000, 2047, 4095};
      int r [5] = '{230, 380, 1500, 3200, 5000};
      for (int i = 0; i < 5; i++) begin
         search_and_check(v[i], r[i], "R4 R5 mixed input");
      end
      // returning to nominal from a high code
      search_and_check(256, 100, "R4 go high");
      search_and_check(200, 275, "R5 back to nominal");
      check(int'(sel) == 4, "R5 nominal regained", int'(sel), 4);
   endtask

   task automatic t_busy_ignore;
      int cyc;
      search_and_check(256, 100, "R9 preset code 8");
      // full sweep 8 -> 0 takes 9 clocks; disturb inputs mid-run
      @(negedge clk);
      vin = 12'd200; vref = 13'd350; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      vin = 12'd4000; vref = 13'd10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 2;
      while (!done && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      check(int'(sel) == model_best(200, 350), "R3 captured inputs used", int'(sel), model_best(200, 350));
      check(cyc == 9, "R9 full sweep length", cyc, 9);
      repeat (12) begin
         @(negedge clk);
         check(done == 1'b0, "R9 start during run ignored", int'(done), 0);
      end
   endtask

   task automatic t_hold;
      int prev;
      prev = int'(sel);
      repeat (10) begin
         @(negedge clk);
         vin = vin + 12'd77; vref = vref + 13'd131;
         check(int'(sel) == prev && done == 1'b0, "R8 code held while idle", int'(sel), prev);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_exact_nominal();
      t_bounds();
      t_ties();
      t_direction();
      t_busy_ignore();
      t_hold();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule